// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust and Status Flags

This block is the arithmetic and logic stage of a small accumulator-based processor. On each cycle where the execute strobe is high it takes the accumulator value, a second operand, an external carry-in and a 4-bit operation code. On the next rising clock edge it loads a registered 8-bit result, a registered 16-bit pair result and a registered 5-bit status word.

Eight-bit operations cover binary add and subtract, each with or without the external carry or borrow. They also cover AND, OR, XOR, complement and four single-bit rotates. A decimal adjust step corrects the accumulator after a packed two-digit BCD addition, using the stored nibble carry and carry flags. A separate pair mode adds two 16-bit register pairs and touches only the carry flag. The status word is kept inside the block, because several operations leave some or all flags at their earlier values.

Top module: `bcd_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `result`, `pair_result` and `flags` become 0.
- R2: Op 0 (add) and op 1 (add with `carry_in`) set `result` to the low 8 bits of `acc + opnd` (+ `carry_in` for op 1) on the edge where `exec_en` is high. CY becomes the carry out of bit 7 and AC becomes the carry out of bit 3.
- R3: Op 2 (subtract) and op 3 (subtract with `carry_in` as borrow) set `result` to the low 8 bits of `acc - opnd` (- `carry_in` for op 3). CY is 1 when the full difference is negative. AC is 1 when the low nibble of `acc` is less than the low nibble of `opnd` plus the borrow.
- R4: Op 4 (AND) forces AC=1 and CY=0. Op 5 (OR) and op 6 (XOR) force AC=0 and CY=0.
- R5: The flag word is `flags[4]`=S, `[3]`=Z, `[2]`=AC, `[1]`=P, `[0]`=CY. Ops 0-6 and op 12 set S to result bit 7 and Z to (result==0). They set P to 1 when the result has an even number of 1 bits.
- R6: Op 7 (complement) sets `result` to `~acc` and leaves all five flags unchanged.
- R7: Op 8 rotates `acc` left and op 9 rotates it right, with the bit shifted out entering both the vacated bit and CY. Op 10 rotates left and op 11 rotates right through the stored CY. All four change only CY.
- R8: Op 12 (decimal adjust) first adds 0x06 if `acc[3:0]` > 9 or AC is set. It then adds 0x60 if the high nibble of that intermediate value is > 9 or CY is set. AC becomes the carry out of bit 3 of the first addition. CY stays set if it was set, and is also set by a carry out of bit 7 in either addition.
- R9: Op 13 (pair add) sets `pair_result` to `(pair_a + pair_b) mod 65536` and CY to the carry out of bit 15. It leaves `result` and the other four flags unchanged.
- R10: When `exec_en` is low, or the op is 14 or 15, no output changes at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe: outputs load at this edge |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| carry_in | input | 1 | External carry or borrow for ops 1 and 3 |
| pair_a | input | 16 | First register pair for op 13 |
| pair_b | input | 16 | Second register pair for op 13 |
| result | output | 8 | Registered 8-bit result |
| pair_result | output | 16 | Registered 16-bit pair sum |
| flags | output | 5 | Registered status word {S,Z,AC,P,CY} |

## Verification
The hardest case to reach is the decimal adjust where both corrections fire and the second one overflows, such as 0x99 + 0x01 giving 0x00 with carry. It depends on flag state left by an earlier operation, and random opcodes rarely follow an add with the right operands. Directed add-then-adjust pairs are therefore mixed into a random stream. A bench model carries the flag state forward, so every adjust, rotate-through-carry and flag-preserving op is checked against the flags that the preceding operations actually produced.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOT  = 4'd7,
    OP_RLC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_RAL  = 4'd10,
    OP_RAR  = 4'd11,
    OP_DAA  = 4'd12,
    OP_DAD  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry_out,
  output logic              nib_carry
);
  logic [DATA_W-1:0] b_x;
  logic              c_x;
  logic [DATA_W:0]   full;

  // subtraction as a + ~b + ~borrow; carry out is then "no borrow"
  assign b_x  = sub ? ~b : b;
  assign c_x  = sub ? ~cin : cin;
  assign full = {1'b0, a} + {1'b0, b_x} + {{DATA_W{1'b0}}, c_x};

  assign sum       = full[DATA_W-1:0];
  assign carry_out = full[DATA_W];
  // carry into bit 4 recovered from the sum bit
  assign nib_carry = a[4] ^ b_x[4] ^ full[4];
endmodule

// File: rtl/alu_daa.sv
module alu_daa #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              ac_in,
  input  logic              cy_in,
  output logic [DATA_W-1:0] y,
  output logic              ac_out,
  output logic              cy_out
);
  localparam int DIGITS = DATA_W / 4;

  logic [DIGITS:0][DATA_W-1:0] stage;
  logic [DIGITS-1:0]           ovf;

  assign stage[0] = a;

  // one correction stage per decimal digit, low digit first
  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic            fl;
    logic            adj;
    logic [DATA_W:0] addend;
    logic [DATA_W:0] nxt;

    assign fl     = (i == 0) ? ac_in : ((i == DIGITS - 1) ? cy_in : 1'b0);
    assign adj    = (stage[i][4*i +: 4] > 4'd9) | fl;
    assign addend = {{(DATA_W-3){1'b0}}, adj, adj, 1'b0} << (4*i);
    assign nxt    = {1'b0, stage[i]} + addend;
    assign stage[i+1] = nxt[DATA_W-1:0];
    assign ovf[i]     = nxt[DATA_W];
  end

  assign y      = stage[DIGITS];
  assign ac_out = stage[1][4] ^ a[4];
  assign cy_out = cy_in | (|ovf);
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                exec_en,
  input  logic [3:0]          op,
  input  logic [DATA_W-1:0]   acc,
  input  logic [DATA_W-1:0]   opnd,
  input  logic                carry_in,
  input  logic [2*DATA_W-1:0] pair_a,
  input  logic [2*DATA_W-1:0] pair_b,
  output logic [DATA_W-1:0]   result,
  output logic [2*DATA_W-1:0] pair_result,
  output logic [4:0]          flags
);
  localparam int PAIR_W = 2 * DATA_W;

  alu_op_e           op_e;
  alu_flags_t        flg_q, flg_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [PAIR_W-1:0] pair_q, pair_d;

  logic              as_sub, as_cin, as_cout, as_nib;
  logic [DATA_W-1:0] as_sum;
  logic [DATA_W-1:0] daa_y;
  logic              daa_ac, daa_cy;
  logic [PAIR_W:0]   psum;
  logic              upd_szp;

  assign op_e   = alu_op_e'(op);
  assign as_sub = (op_e == OP_SUB) || (op_e == OP_SBB);
  assign as_cin = ((op_e == OP_ADC) || (op_e == OP_SBB)) ? carry_in : 1'b0;

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(acc), .b(opnd), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .carry_out(as_cout), .nib_carry(as_nib)
  );

  alu_daa #(.DATA_W(DATA_W)) u_daa (
    .a(acc), .ac_in(flg_q.ac), .cy_in(flg_q.cy),
    .y(daa_y), .ac_out(daa_ac), .cy_out(daa_cy)
  );

  assign psum = {1'b0, pair_a} + {1'b0, pair_b};

  always_comb begin
    res_d   = res_q;
    pair_d  = pair_q;
    flg_d   = flg_q;
    upd_szp = 1'b0;
    unique case (op_e)
      OP_ADD, OP_ADC: begin
        res_d = as_sum; flg_d.cy = as_cout; flg_d.ac = as_nib; upd_szp = 1'b1;
      end
      OP_SUB, OP_SBB: begin
        res_d = as_sum; flg_d.cy = ~as_cout; flg_d.ac = ~as_nib; upd_szp = 1'b1;
      end
      OP_AND: begin
        res_d = acc & opnd; flg_d.cy = 1'b0; flg_d.ac = 1'b1; upd_szp = 1'b1;
      end
      OP_OR: begin
        res_d = acc | opnd; flg_d.cy = 1'b0; flg_d.ac = 1'b0; upd_szp = 1'b1;
      end
      OP_XOR: begin
        res_d = acc ^ opnd; flg_d.cy = 1'b0; flg_d.ac = 1'b0; upd_szp = 1'b1;
      end
      OP_NOT: res_d = ~acc;
      OP_RLC: begin
        res_d = {acc[DATA_W-2:0], acc[DATA_W-1]}; flg_d.cy = acc[DATA_W-1];
      end
      OP_RRC: begin
        res_d = {acc[0], acc[DATA_W-1:1]}; flg_d.cy = acc[0];
      end
      OP_RAL: begin
        res_d = {acc[DATA_W-2:0], flg_q.cy}; flg_d.cy = acc[DATA_W-1];
      end
      OP_RAR: begin
        res_d = {flg_q.cy, acc[DATA_W-1:1]}; flg_d.cy = acc[0];
      end
      OP_DAA: begin
        res_d = daa_y; flg_d.ac = daa_ac; flg_d.cy = daa_cy; upd_szp = 1'b1;
      end
      OP_DAD: begin
        pair_d = psum[PAIR_W-1:0]; flg_d.cy = psum[PAIR_W];
      end
      default: ;
    endcase
    if (upd_szp) begin
      flg_d.s = res_d[DATA_W-1];
      flg_d.z = (res_d == '0);
      flg_d.p = ~^res_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      pair_q <= '0;
      flg_q  <= '0;
    end else if (exec_en) begin
      res_q  <= res_d;
      pair_q <= pair_d;
      flg_q  <= flg_d;
    end
  end

  assign result      = res_q;
  assign pair_result = pair_q;
  assign flags       = flg_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(result) && $stable(flags) && $stable(pair_result)); // R10
  AST_NOT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_e == OP_NOT |=> flags == $past(flags)); // R6
  AST_ROT_CY_ONLY: assert property (@(posedge clk) disable iff (rst)
    exec_en && (op_e inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR})
    |=> flags[4:1] == $past(flags[4:1])); // R7
  AST_PAIR_CY_ONLY: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_e == OP_DAD
    |=> flags[4:1] == $past(flags[4:1]) && result == $past(result)); // R9
  AST_AND_FLAGS: assert property (@(posedge clk) disable iff (rst)
    exec_en && op_e == OP_AND |=> flags[2] && !flags[0]); // R4
  AST_ORX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    exec_en && (op_e inside {OP_OR, OP_XOR}) |=> !flags[2] && !flags[0]); // R4
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    exec_en && (op_e inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_OR, OP_XOR, OP_DAA})
    |=> flags[3] == (result == '0)); // R5
  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (rst)
    exec_en && (op_e inside {OP_RSV0, OP_RSV1})
    |=> $stable(result) && $stable(flags) && $stable(pair_result)); // R10
endmodule

// File: tb/bcd_alu_bench.sv
`timescale 1ns/1ps
module bcd_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_en = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [7:0]  acc = 8'd0, opnd = 8'd0;
  logic        carry_in = 1'b0;
  logic [15:0] pair_a = 16'd0, pair_b = 16'd0;
  logic [7:0]  result;
  logic [15:0] pair_result;
  logic [4:0]  flags;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0]  e_res = 8'd0;
  logic [4:0]  e_f = 5'd0;
  logic [15:0] e_p = 16'd0;

  always #2.5 clk = ~clk;

  bcd_alu u_bcd_alu (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op(op), .acc(acc), .opnd(opnd),
    .carry_in(carry_in), .pair_a(pair_a), .pair_b(pair_b),
    .result(result), .pair_result(pair_result), .flags(flags)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:             return "R2 R5";
      4'd2, 4'd3:             return "R3 R5";
      4'd4, 4'd5, 4'd6:       return "R4 R5";
      4'd7:                   return "R6";
      4'd8, 4'd9, 4'd10, 4'd11: return "R7";
      4'd12:                  return "R8 R5";
      4'd13:                  return "R9";
      default:                return "R10";
    endcase
  endfunction

  // expected {result, flags, pair_result} from the requirements
  function automatic logic [28:0] model(input logic [3:0] o, input logic [7:0] a, b,
                                        input logic ci, input logic [4:0] f,
                                        input logic [15:0] pa, pb,
                                        input logic [7:0] r0, input logic [15:0] p0);
    logic [7:0]  r;
    logic [15:0] p;
    logic [4:0]  nf;
    bit          szp;
    int          t, lo, bw;
    bit          la, ha, c1, c2;
    r = r0; p = p0; nf = f; szp = 0;
    case (o)
      4'd0, 4'd1: begin
        bw = (o == 4'd1) ? int'(ci) : 0;
        t = int'(a) + int'(b) + bw; lo = int'(a[3:0]) + int'(b[3:0]) + bw;
        r = t[7:0]; nf[0] = (t > 255); nf[2] = (lo > 15); szp = 1;
      end
      4'd2, 4'd3: begin
        bw = (o == 4'd3) ? int'(ci) : 0;
        t = int'(a) - int'(b) - bw;
        r = t[7:0]; nf[0] = (t < 0); nf[2] = (int'(a[3:0]) < int'(b[3:0]) + bw); szp = 1;
      end
      4'd4: begin r = a & b; nf[0] = 0; nf[2] = 1; szp = 1; end
      4'd5: begin r = a | b; nf[0] = 0; nf[2] = 0; szp = 1; end
      4'd6: begin r = a ^ b; nf[0] = 0; nf[2] = 0; szp = 1; end
      4'd7: r = ~a;
      4'd8: begin r = {a[6:0], a[7]}; nf[0] = a[7]; end
      4'd9: begin r = {a[0], a[7:1]}; nf[0] = a[0]; end
      4'd10: begin r = {a[6:0], f[0]}; nf[0] = a[7]; end
      4'd11: begin r = {f[0], a[7:1]}; nf[0] = a[0]; end
      4'd12: begin
        la = (a[3:0] > 4'd9) || f[2];
        t = int'(a) + (la ? 6 : 0);
        nf[2] = ((int'(a[3:0]) + (la ? 6 : 0)) > 15);
        c1 = (t > 255); t = t & 255;
        ha = (((t >> 4) & 15) > 9) || f[0];
        t = t + (ha ? 96 : 0);
        c2 = (t > 255);
        r = t[7:0]; nf[0] = f[0] | c1 | c2; szp = 1;
      end
      4'd13: begin
        t = int'(pa) + int'(pb); p = t[15:0]; nf[0] = (t > 65535);
      end
      default: ;
    endcase
    if (szp) begin nf[4] = r[7]; nf[3] = (r == 8'd0); nf[1] = ~^r; end
    return {r, nf, p};
  endfunction

  task automatic check_out(input string tag);
    total++;
    if (result !== e_res || flags !== e_f || pair_result !== e_p) begin
      bad++;
      $display("FAIL %s: res=%h flags=%b pair=%h expected res=%h flags=%b pair=%h",
               tag, result, flags, pair_result, e_res, e_f, e_p);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [7:0] a, b, input logic ci,
                        input logic [15:0] pa, pb);
    @(negedge clk);
    op = o; acc = a; opnd = b; carry_in = ci; pair_a = pa; pair_b = pb; exec_en = 1'b1;
    {e_res, e_f, e_p} = model(o, a, b, ci, e_f, pa, pb, e_res, e_p);
    @(negedge clk);
    exec_en = 1'b0;
    check_out($sformatf("%s op=%0d a=%h b=%h ci=%0d", tag_of(o), o, a, b, ci));
  endtask

  task automatic idle_step();
    @(negedge clk);
    op = 4'($urandom_range(0, 13)); acc = 8'($urandom); opnd = 8'($urandom);
    pair_a = 16'($urandom); pair_b = 16'($urandom); exec_en = 1'b0;
    @(negedge clk);
    check_out("R10 idle");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20513));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 reset");

    // directed corner cases
    run_op(4'd0, 8'h80, 8'h80, 1'b0, 16'h0, 16'h0);   // R5 zero, even parity, carry
    run_op(4'd1, 8'h0F, 8'h00, 1'b1, 16'h0, 16'h0);   // R2 nibble carry via carry_in
    run_op(4'd2, 8'h00, 8'h01, 1'b0, 16'h0, 16'h0);   // R3 borrow
    run_op(4'd3, 8'h10, 8'h00, 1'b1, 16'h0, 16'h0);   // R3 nibble borrow
    run_op(4'd7, 8'h5A, 8'h00, 1'b0, 16'h0, 16'h0);   // R6 flags kept
    run_op(4'd10, 8'h01, 8'h00, 1'b0, 16'h0, 16'h0);  // R7 through carry
    run_op(4'd11, 8'h01, 8'h00, 1'b0, 16'h0, 16'h0);  // R7
    run_op(4'd4, 8'hF0, 8'h0F, 1'b0, 16'h0, 16'h0);   // R4 AND sets AC
    run_op(4'd6, 8'hFF, 8'h0F, 1'b0, 16'h0, 16'h0);   // R4 XOR clears
    run_op(4'd0, 8'h15, 8'h27, 1'b0, 16'h0, 16'h0);   // R8 setup
    run_op(4'd12, 8'h3C, 8'h00, 1'b0, 16'h0, 16'h0);  // R8 -> 42
    run_op(4'd0, 8'h99, 8'h01, 1'b0, 16'h0, 16'h0);
    run_op(4'd12, 8'h9A, 8'h00, 1'b0, 16'h0, 16'h0);  // R8 -> 00 with carry
    run_op(4'd0, 8'h09, 8'h08, 1'b0, 16'h0, 16'h0);
    run_op(4'd12, 8'h11, 8'h00, 1'b0, 16'h0, 16'h0);  // R8 AC-driven adjust
    run_op(4'd13, 8'h00, 8'h00, 1'b0, 16'hFFFF, 16'h0001); // R9 wrap
    run_op(4'd13, 8'h00, 8'h00, 1'b0, 16'h1234, 16'h4321); // R9
    run_op(4'd14, 8'hAA, 8'h55, 1'b1, 16'h1, 16'h1);  // R10 reserved
    run_op(4'd15, 8'h55, 8'hAA, 1'b0, 16'h2, 16'h2);  // R10 reserved
    idle_step();
    idle_step();

    // random stream, with occasional BCD add-then-adjust pairs
    for (int i = 0; i < 400; i++) begin
      if ((i % 10) == 0) begin
        logic [7:0] x, y;
        x = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
        y = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
        run_op(4'd0, x, y, 1'b0, 16'h0, 16'h0);
        run_op(4'd12, e_res, 8'h00, 1'b0, 16'h0, 16'h0);
      end else if ((i % 37) == 0) begin
        idle_step();
      end else begin
        run_op(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
               16'($urandom), 16'($urandom));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule